// File: doc/BRIEF.md
# Fractional Multiply-Accumulate ALU for an Audio Effects DSP

This block is the arithmetic stage of a 32-bit audio effects processor. Each cycle it can accept one operation: a 4-bit opcode and three signed operands, A, X and Y. One clock later it returns a registered result R, a condition flag word, a saturation event pulse and an unsupported-op indication. The opcodes cover several groups: Q31 fractional multiply-accumulate (saturating and wrapping, with a plain or negated product), integer multiply-accumulate, a three-input add, an AND/XOR logic step, compare-and-select limits, conditional complement and linear interpolation.

A 64-bit side accumulator is updated by a dedicated opcode, and R of that opcode is A unchanged. The product is added at Q63 scale, so the upper half of the accumulator, which is exposed as a port, holds the Q31 running sum. The remaining lower bits keep the truncated fractional part of the products.

Top module: `dsp_mac_alu`

## Requirements
- R1: `res_valid` is high exactly in the cycle after each cycle with `op_valid` high. `res`, `flags`, `unsup` and `sat_evt` change only on such cycles, and `sat_evt` and `unsup` are low whenever `res_valid` is low.
- R2: With P = X*Y as an exact signed product, opcode 0 gives sat(A + (P>>>31)) and opcode 1 gives sat(A + ((-P)>>>31)). Opcodes 2 and 3 give the same two sums truncated to the low 32 bits (wraparound).
- R3: Opcode 4 gives sat(A + P). Opcode 5 takes the low 31 bits of A + P and sign-extends them from bit 30 into bit 31.
- R4: Opcode 6 gives sat(A + X + Y).
- R5: Opcode 7 gives R = A and adds P shifted left by one (modulo 2^64) into the 64-bit accumulator. `acc_hi` shows accumulator bits 63:32. No other opcode changes the accumulator.
- R6: Opcode 8 gives (A & X) ^ Y. Opcode 9 gives X when A >= Y (signed), otherwise ~X.
- R7: Opcode 10 gives X when A >= Y, otherwise Y. Opcode 11 gives X when A < Y, otherwise Y. Both comparisons are signed.
- R8: Opcode 14 gives sat(A + ((X*(Y-A))>>>31)), with Y-A computed exactly.
- R9: sat() clamps results above 0x7FFFFFFF to 0x7FFFFFFF and results below -2^31 to 0x80000000. A clamp sets flag bit 4 and pulses `sat_evt` together with the result. Wrapping, logic and select opcodes never saturate.
- R10: The flag bits describe R. Bit 0 is R[31]^R[30] (normalized). Bit 1 is set for opcodes 9, 10 and 11 when A < Y (borrow). Bit 2 is R[31]. Bit 3 is R==0. Bit 4 is saturation. Bit 8 is R!=0. Bits 5 to 7 are zero.
- R11: Opcodes 12, 13 and 15 give R = A, never saturate and raise `unsup` with the result. All other opcodes leave `unsup` low.
- R12: Reset clears `res`, `flags`, `res_valid`, `sat_evt`, `unsup` and the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe |
| opcode | input | 4 | Operation code |
| opa | input | 32 | Operand A (signed) |
| opx | input | 32 | Operand X (signed) |
| opy | input | 32 | Operand Y (signed) |
| res_valid | output | 1 | Result valid, one cycle after op_valid |
| res | output | 32 | Result R |
| flags | output | 9 | Condition flags |
| sat_evt | output | 1 | Saturation occurred in this result |
| unsup | output | 1 | Opcode not implemented by this block |
| acc_hi | output | 32 | Accumulator bits 63:32 |

## Verification
Directed vectors sit on the limits of each opcode group. Half-scale products tell the fractional shift apart from the integer sum. Near-full-scale A pushes the saturating and wrapping twins in opposite directions. The -1 x -1 product is the only case whose negated-product shift differs from the shifted negative. Equal A and Y separate >= from <, and a run of accumulate operations interleaved with other opcodes shows that only opcode 7 moves the accumulator. Random operands over all sixteen opcodes, sent with idle gaps, then exercise the flag bits across signs and zero and check that the outputs hold between results.

// File: rtl/dsp_mac_alu.sv
module dsp_mac_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opx,
  input  logic [W-1:0] opy,
  output logic         res_valid,
  output logic [W-1:0] res,
  output logic [8:0]   flags,
  output logic         sat_evt,
  output logic         unsup,
  output logic [W-1:0] acc_hi
);
  localparam int AW = 2 * W;
  localparam int EW = 2 * W + 2;
  localparam int SH = W - 1;
  localparam logic signed [EW-1:0] MAXV = EW'((64'sd1 <<< (W - 1)) - 1);
  localparam logic signed [EW-1:0] MINV = -EW'(64'sd1 <<< (W - 1));

  logic signed [EW-1:0] ea, ex, ey, ep, epn, dif, pint;
  logic signed [EW-1:0] s_frac, s_nfrac, s_int, s_add3, s_interp;
  logic [AW-1:0] acc;

  assign ea  = EW'($signed(opa));
  assign ex  = EW'($signed(opx));
  assign ey  = EW'($signed(opy));
  assign ep  = ex * ey;
  assign epn = -ep;
  assign dif = ey - ea;
  assign pint = ex * dif;

  assign s_frac   = ea + (ep >>> SH);
  assign s_nfrac  = ea + (epn >>> SH);
  assign s_int    = ea + ep;
  assign s_add3   = ea + ex + ey;
  assign s_interp = ea + (pint >>> SH);

  function automatic logic [W:0] clamp(input logic signed [EW-1:0] v);
    if (v > MAXV) return {1'b1, 1'b0, {(W-1){1'b1}}};
    if (v < MINV) return {1'b1, 1'b1, {(W-1){1'b0}}};
    return {1'b0, v[W-1:0]};
  endfunction

  logic ge;
  assign ge = $signed(opa) >= $signed(opy);

  logic [W:0]   sel;
  logic [W-1:0] rn;
  logic         satn, borrown, unsn;

  always_comb begin
    sel     = {1'b0, opa};
    borrown = 1'b0;
    unsn    = 1'b0;
    case (opcode)
      4'd0:  sel = clamp(s_frac);
      4'd1:  sel = clamp(s_nfrac);
      4'd2:  sel = {1'b0, s_frac[W-1:0]};
      4'd3:  sel = {1'b0, s_nfrac[W-1:0]};
      4'd4:  sel = clamp(s_int);
      4'd5:  sel = {1'b0, s_int[W-2], s_int[W-2:0]};
      4'd6:  sel = clamp(s_add3);
      4'd7:  sel = {1'b0, opa};
      4'd8:  sel = {1'b0, (opa & opx) ^ opy};
      4'd9:  begin sel = {1'b0, ge ? opx : ~opx}; borrown = !ge; end
      4'd10: begin sel = {1'b0, ge ? opx : opy};  borrown = !ge; end
      4'd11: begin sel = {1'b0, ge ? opy : opx};  borrown = !ge; end
      4'd14: sel = clamp(s_interp);
      default: unsn = 1'b1;
    endcase
  end

  assign rn   = sel[W-1:0];
  assign satn = sel[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
      flags     <= '0;
      sat_evt   <= 1'b0;
      unsup     <= 1'b0;
      acc       <= '0;
    end else begin
      res_valid <= op_valid;
      sat_evt   <= op_valid && satn;
      unsup     <= op_valid && unsn;
      if (op_valid) begin
        res   <= rn;
        flags <= {rn != '0, 3'b000, satn, rn == '0, rn[W-1], borrown, rn[W-1] ^ rn[W-2]};
        if (opcode == 4'd7) acc <= acc + (ep[AW-1:0] << 1);
      end
    end
  end

  assign acc_hi = acc[AW-1:W];

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) op_valid |=> res_valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid && $stable(res) && $stable(flags) && !sat_evt && !unsup);
  // R9
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |-> res_valid && flags[4] && (res == {1'b0, {(W-1){1'b1}}} || res == {1'b1, {(W-1){1'b0}}}));
  // R5
  acc_only_op7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && opcode == 4'd7) |=> $stable(acc_hi));
  // R10
  zero_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags[3] != flags[8]) && (flags[7:5] == 3'b000));
  // R11
  unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |-> res_valid && !sat_evt);
endmodule

// File: tb/dsp_mac_alu_tb.sv
module dsp_mac_alu_tb;
  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [3:0] opcode = 0;
  logic [31:0] opa = 0, opx = 0, opy = 0;
  logic res_valid, sat_evt, unsup;
  logic [31:0] res, acc_hi;
  logic [8:0] flags;

  dsp_mac_alu u_dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .opa(opa), .opx(opx), .opy(opy), .res_valid(res_valid), .res(res), .flags(flags),
    .sat_evt(sat_evt), .unsup(unsup), .acc_hi(acc_hi));

  always #5 clk = ~clk;

  typedef struct { logic [3:0] op; logic [31:0] r; logic [8:0] f; logic s; logic u; logic [31:0] ah; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  longint macc = 0;
  logic [31:0] last_r = 0;
  logic [8:0] last_f = 0;
  bit done = 0;

  function automatic string tag(input logic [3:0] op);
    case (op)
      0, 1, 2, 3: return "R2";
      4, 5: return "R3";
      6: return "R4";
      7: return "R5";
      8, 9: return "R6";
      10, 11: return "R7";
      14: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic longint sx(input logic [31:0] v);
    return longint'($signed(v));
  endfunction

  task automatic sat(input longint v, output logic [31:0] r, output logic s);
    if (v > 64'sd2147483647) begin r = 32'h7FFFFFFF; s = 1; end
    else if (v < -64'sd2147483648) begin r = 32'h80000000; s = 1; end
    else begin r = v[31:0]; s = 0; end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] x, input logic [31:0] y, input int gap);
    item_t it;
    longint p, t;
    logic s;
    logic b;
    p = sx(x) * sx(y);
    s = 0; b = 0; it.u = 0; it.r = a;
    case (op)
      0: sat(sx(a) + (p >>> 31), it.r, s);
      1: sat(sx(a) + ((-p) >>> 31), it.r, s);
      2: begin t = sx(a) + (p >>> 31); it.r = t[31:0]; end
      3: begin t = sx(a) + ((-p) >>> 31); it.r = t[31:0]; end
      4: sat(sx(a) + p, it.r, s);
      5: begin t = sx(a) + p; it.r = {t[30], t[30:0]}; end
      6: sat(sx(a) + sx(x) + sx(y), it.r, s);
      7: begin it.r = a; macc = macc + (p <<< 1); end
      8: it.r = (a & x) ^ y;
      9: begin b = sx(a) < sx(y); it.r = b ? ~x : x; end
      10: begin b = sx(a) < sx(y); it.r = b ? y : x; end
      11: begin b = sx(a) < sx(y); it.r = b ? x : y; end
      14: sat(sx(a) + ((sx(x) * (sx(y) - sx(a))) >>> 31), it.r, s);
      default: it.u = 1;
    endcase
    it.op = op; it.s = s; it.ah = macc[63:32];
    it.f = {it.r != 0, 3'b000, s, it.r == 0, it.r[31], b, it.r[31] ^ it.r[30]};
    @(negedge clk);
    op_valid = 1; opcode = op; opa = a; opx = x; opy = y;
    q.push_back(it);
    @(negedge clk);
    op_valid = 0; opa = $urandom; opx = $urandom; opy = $urandom; opcode = 4'($urandom);
    repeat (gap) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (res_valid) begin
        item_t e;
        checks++;
        if (q.size() == 0) begin
          fails++; $display("FAIL R1 unexpected res_valid act=1 exp=0");
        end else begin
          e = q.pop_front();
          if (res !== e.r) begin fails++; $display("FAIL %s op%0d res act=%h exp=%h", tag(e.op), e.op, res, e.r); end
          else if (flags !== e.f) begin fails++; $display("FAIL R10 op%0d flags act=%h exp=%h", e.op, flags, e.f); end
          else if (sat_evt !== e.s) begin fails++; $display("FAIL R9 op%0d sat_evt act=%b exp=%b", e.op, sat_evt, e.s); end
          else if (unsup !== e.u) begin fails++; $display("FAIL R11 op%0d unsup act=%b exp=%b", e.op, unsup, e.u); end
          else if (acc_hi !== e.ah) begin fails++; $display("FAIL R5 op%0d acc_hi act=%h exp=%h", e.op, acc_hi, e.ah); end
        end
        last_r = res; last_f = flags;
      end else begin
        if (q.size() != 0 || res !== last_r || flags !== last_f || sat_evt || unsup) begin
          checks++; fails++;
          $display("FAIL R1 idle cycle res act=%h exp=%h pending=%0d", res, last_r, q.size());
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (res_valid || res != 0 || flags != 0 || sat_evt || unsup || acc_hi != 0) begin
      fails++; $display("FAIL R12 reset state act=%h/%h exp=0/0", res, acc_hi);
    end
    rst_n = 1;
    // R2 fractional, half scale and saturation against wrap
    drive(0, 32'h10000000, 32'h40000000, 32'h40000000, 0);
    drive(0, 32'h7FFFFFFF, 32'h40000000, 32'h40000000, 1);
    drive(2, 32'h7FFFFFFF, 32'h40000000, 32'h40000000, 0);
    drive(1, 32'h80000000, 32'h40000000, 32'h40000000, 0);
    drive(3, 32'h80000000, 32'h40000000, 32'h40000000, 2);
    drive(1, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    drive(0, 32'h00000000, 32'h80000000, 32'h80000000, 0);
    // R3 integer sums
    drive(4, 32'h00000005, 32'h00000003, 32'h00000007, 0);
    drive(4, 32'h7FFFFFF0, 32'h00010000, 32'h00010000, 0);
    drive(5, 32'h3FFFFFFF, 32'h00000001, 32'h00000001, 0);
    drive(5, 32'h00000000, 32'hFFFFFFFF, 32'h00000001, 0);
    // R4, R9 three-way add
    drive(6, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 0);
    drive(6, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 0);
    drive(6, 32'h00000010, 32'hFFFFFFF0, 32'h00000000, 0);
    // R5 accumulator, interleaved with other ops
    drive(7, 32'h12345678, 32'h40000000, 32'h40000000, 0);
    drive(8, 32'hFFFF0000, 32'h0F0F0F0F, 32'h00FF00FF, 0);
    drive(7, 32'hCAFEF00D, 32'hC0000000, 32'h20000000, 1);
    drive(7, 32'h00000000, 32'h00000003, 32'h00000005, 0);
    // R6, R7 compare on equality and sign
    drive(9, 32'h00000005, 32'h0000AAAA, 32'h00000005, 0);
    drive(9, 32'hFFFFFFFF, 32'h0000AAAA, 32'h00000000, 0);
    drive(10, 32'h00000005, 32'h00000011, 32'h00000005, 0);
    drive(10, 32'h80000000, 32'h00000011, 32'h7FFFFFFF, 0);
    drive(11, 32'h00000005, 32'h00000011, 32'h00000005, 0);
    drive(11, 32'h80000000, 32'h00000011, 32'h7FFFFFFF, 0);
    // R8 interpolation endpoints and midpoint
    drive(14, 32'h10000000, 32'h40000000, 32'h30000000, 0);
    drive(14, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 0);
    drive(14, 32'h00001000, 32'h00000000, 32'h7FFFFFFF, 0);
    // R11 unsupported opcodes
    drive(12, 32'hDEADBEEF, 32'h1, 32'h2, 0);
    drive(13, 32'h00000000, 32'h1, 32'h2, 0);
    drive(15, 32'h80000000, 32'h1, 32'h2, 1);
    // random sweep (R10 flags over all opcodes)
    for (int i = 0; i < 400; i++)
      drive(4'($urandom), $urandom, $urandom, $urandom, int'($urandom % 3));
    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule